// File: doc/BRIEF.md
# PLL Reference Clock Switch Sequencer

This block changes which reference clock input drives a transceiver PLL by driving register accesses on the PLL's memory-mapped reconfiguration bus. The user raises a request together with a logical clock index. The block checks the index against the number of configured clocks. It then gains the bus through a request/grant pair and reads the lookup register that belongs to that index, keeping the low byte. Next it reads the clock-select register and writes it back with only its low byte replaced by the kept byte. Finally it drops the bus request and pulses done.

The value placed into the select register does not come from the index itself. It is fetched from a per-clock lookup register, so the routing of a logical index onto a physical clock stays in the PLL's own register space. The select register address depends on the PLL mode parameter. The block only moves register values; the register file and the PLL behind it are outside it.

Top module: `refclk_switch_seq`

## Requirements
- R1: When idle and a request with a valid index is sampled, busy_o and arb_req_o are high from the next cycle on. No bus read or write starts before arb_gnt_i has been sampled high.
- R2: The first bus access of a switch is a read at address 0x117 plus the requested index.
- R3: The second access is a read of the select register, and the third is a write to the same register. The select register is at 0x112 when PLL_MODE is 0 and at 0x115 when PLL_MODE is 1.
- R4: The written word equals the word read from the select register with bits [7:0] replaced by bits [7:0] of the lookup read. Bits 31:8 are written back unchanged.
- R5: While bus_waitreq_i is high during an access, the bus command, address and write data do not change. A transfer completes at a clock edge where the command is high and bus_waitreq_i is low, and read data is taken at that edge.
- R6: When idle and a request arrives whose index is greater than or equal to NUM_CLKS, or when NUM_CLKS is 1, err_o pulses high for exactly one cycle on the next cycle. busy_o and arb_req_o stay low, and no bus access starts.
- R7: done_o pulses high for exactly one cycle, on the cycle after the write completes. In that cycle busy_o and arb_req_o are already low.
- R8: Requests sampled while busy_o is high are ignored. They change neither the switch in progress nor err_o.
- R9: After reset, busy_o, done_o, err_o, arb_req_o, bus_read_o and bus_write_o are low.
- R10: bus_read_o and bus_write_o are never high together, and either one is high only while arb_req_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Switch request, sampled when idle |
| idx_i | input | IDX_W | Logical reference clock index |
| busy_o | output | 1 | Switch in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for a rejected request |
| arb_req_o | output | 1 | Bus access request |
| arb_gnt_i | input | 1 | Bus access grant |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_read_o | output | 1 | Bus read command |
| bus_write_o | output | 1 | Bus write command |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_rdata_i | input | DATA_W | Bus read data |
| bus_waitreq_i | input | 1 | Bus stall, holds the current access |

## Verification
The bench builds the block with NUM_CLKS of 4 and PLL_MODE of 0. This makes index 4 a rejected value even though it fits the index width, and index 7 a second rejected value at the top of the width. The lookup words and the select word carry nonzero upper bits, so a write that loses bits 31:8 or copies the full lookup word is visible in the final register contents. The stall and grant patterns come from a shift register in the bench, which puts stalls on every access type and makes grants arrive after varying delays. Requests are also issued in the middle of switches, including during stalls.

// File: rtl/refclk_sw_pkg.sv
package refclk_sw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARB,
    ST_RD_LU,
    ST_RD_SEL,
    ST_WR_SEL
  } seq_st_e;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_RD,
    CMD_WR
  } bus_cmd_e;

  localparam int unsigned MAX_CLKS = 5;
  localparam int unsigned LU_BASE  = 'h117;

  function automatic int unsigned sel_addr(input int unsigned mode);
    return (mode == 0) ? 'h112 : 'h115;
  endfunction
endpackage

// File: rtl/refclk_idx_check.sv
module refclk_idx_check #(
  parameter int unsigned NUM_CLKS = 5,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned ADDR_W   = 10
) (
  input  logic [IDX_W-1:0]  req_idx_i,
  input  logic [IDX_W-1:0]  cur_idx_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] lu_addr_o
);
  import refclk_sw_pkg::*;

  generate
    if (NUM_CLKS <= 1) begin : g_single
      // one configured clock: nothing to switch to
      assign valid_o = 1'b0;
    end else begin : g_multi
      assign valid_o = (32'(req_idx_i) < NUM_CLKS);
    end
  endgenerate

  assign lu_addr_o = ADDR_W'(LU_BASE + 32'(cur_idx_i));
endmodule

// File: rtl/refclk_bus_port.sv
module refclk_bus_port #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  refclk_sw_pkg::bus_cmd_e   cmd_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  input  logic                      waitreq_i,
  output logic                      read_o,
  output logic                      write_o,
  output logic [ADDR_W-1:0]         addr_o,
  output logic [DATA_W-1:0]         wdata_o,
  output logic                      xfer_done_o
);
  import refclk_sw_pkg::*;

  assign read_o      = (cmd_i == CMD_RD);
  assign write_o     = (cmd_i == CMD_WR);
  assign addr_o      = (cmd_i == CMD_NONE) ? '0 : addr_i;
  assign wdata_o     = write_o ? wdata_i : '0;
  assign xfer_done_o = (read_o || write_o) && !waitreq_i;

  // R5
  rd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (read_o && waitreq_i) |=> (read_o && $stable(addr_o)));
  // R5
  wr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (write_o && waitreq_i) |=> (write_o && $stable(addr_o) && $stable(wdata_o)));
endmodule

// File: rtl/refclk_seq_fsm.sv
module refclk_seq_fsm #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_i,
  input  logic                     idx_valid_i,
  input  logic                     gnt_i,
  input  logic                     xfer_done_i,
  input  logic [DATA_W-1:0]        rdata_i,
  output refclk_sw_pkg::seq_st_e   state_o,
  output logic                     take_idx_o,
  output logic [DATA_W-1:0]        sel_word_o,
  output logic                     done_o,
  output logic                     err_o
);
  import refclk_sw_pkg::*;

  seq_st_e          st_q, st_d;
  logic [7:0]       lut_q;
  logic [DATA_W-1:0] sel_q;
  logic             done_q, err_q;

  assign take_idx_o = (st_q == ST_IDLE) && req_i && idx_valid_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (take_idx_o) st_d = ST_ARB;
      ST_ARB:    if (gnt_i) st_d = ST_RD_LU;
      ST_RD_LU:  if (xfer_done_i) st_d = ST_RD_SEL;
      ST_RD_SEL: if (xfer_done_i) st_d = ST_WR_SEL;
      ST_WR_SEL: if (xfer_done_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      lut_q  <= '0;
      sel_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= (st_q == ST_WR_SEL) && xfer_done_i;
      err_q  <= (st_q == ST_IDLE) && req_i && !idx_valid_i;
      if (st_q == ST_RD_LU && xfer_done_i) lut_q <= rdata_i[7:0];
      // keep upper select bits, splice in the looked-up byte
      if (st_q == ST_RD_SEL && xfer_done_i) sel_q <= {rdata_i[DATA_W-1:8], lut_q};
    end
  end

  assign state_o    = st_q;
  assign sel_word_o = sel_q;
  assign done_o     = done_q;
  assign err_o      = err_q;

  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R6
  err_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  // R6
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (st_q == ST_IDLE));
  // R1
  wait_gnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ARB && !gnt_i) |=> (st_q == ST_ARB));
endmodule

// File: rtl/refclk_switch_seq.sv
module refclk_switch_seq #(
  parameter int unsigned NUM_CLKS = 5,
  parameter int unsigned PLL_MODE = 0,
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned IDX_W    = $clog2(refclk_sw_pkg::MAX_CLKS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              arb_req_o,
  input  logic              arb_gnt_i,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_read_o,
  output logic              bus_write_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i,
  input  logic              bus_waitreq_i
);
  import refclk_sw_pkg::*;

  localparam logic [ADDR_W-1:0] SEL_A = ADDR_W'(sel_addr(PLL_MODE));

  seq_st_e           st;
  bus_cmd_e          cmd;
  logic [IDX_W-1:0]  idx_q;
  logic              idx_ok, take_idx, xfer_done;
  logic [ADDR_W-1:0] lu_addr, cmd_addr;
  logic [DATA_W-1:0] sel_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       idx_q <= '0;
    else if (take_idx) idx_q <= idx_i;
  end

  refclk_idx_check #(
    .NUM_CLKS(NUM_CLKS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
  ) u_chk (
    .req_idx_i(idx_i),
    .cur_idx_i(idx_q),
    .valid_o  (idx_ok),
    .lu_addr_o(lu_addr)
  );

  refclk_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .idx_valid_i(idx_ok),
    .gnt_i      (arb_gnt_i),
    .xfer_done_i(xfer_done),
    .rdata_i    (bus_rdata_i),
    .state_o    (st),
    .take_idx_o (take_idx),
    .sel_word_o (sel_word),
    .done_o     (done_o),
    .err_o      (err_o)
  );

  always_comb begin
    cmd      = CMD_NONE;
    cmd_addr = '0;
    unique case (st)
      ST_RD_LU:  begin cmd = CMD_RD; cmd_addr = lu_addr; end
      ST_RD_SEL: begin cmd = CMD_RD; cmd_addr = SEL_A;   end
      ST_WR_SEL: begin cmd = CMD_WR; cmd_addr = SEL_A;   end
      default:   ;
    endcase
  end

  refclk_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .addr_i     (cmd_addr),
    .wdata_i    (sel_word),
    .waitreq_i  (bus_waitreq_i),
    .read_o     (bus_read_o),
    .write_o    (bus_write_o),
    .addr_o     (bus_addr_o),
    .wdata_o    (bus_wdata_o),
    .xfer_done_o(xfer_done)
  );

  assign busy_o    = (st != ST_IDLE);
  assign arb_req_o = (st != ST_IDLE);

  // R10
  rw_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_read_o && bus_write_o));
  // R10
  cmd_owned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_read_o || bus_write_o) |-> arb_req_o);
  // R7
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!arb_req_o && !busy_o));
  // R8
  busy_hold_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(idx_q));
endmodule

// File: tb/refclk_switch_seq_tb_top.sv
module refclk_switch_seq_tb_top;
  localparam int CLK_P    = 10;
  localparam int NCLK     = 4;
  localparam int MODE     = 0;
  localparam int AW       = 10;
  localparam int DW       = 32;
  localparam int IW       = 3;
  localparam int SEL_A    = (MODE == 0) ? 'h112 : 'h115;
  localparam int LU_A     = 'h117;

  logic clk = 0, rst_n = 0;
  logic req = 0, gnt = 0, waitreq = 0;
  logic [IW-1:0] idx = '0;
  logic busy, done, err, arb_req, rd, wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  logic [DW-1:0] rf [0:(1<<AW)-1];
  int n_chk = 0, n_fail = 0, cyc = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  refclk_switch_seq #(.NUM_CLKS(NCLK), .PLL_MODE(MODE), .ADDR_W(AW), .DATA_W(DW), .IDX_W(IW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .idx_i(idx),
    .busy_o(busy), .done_o(done), .err_o(err),
    .arb_req_o(arb_req), .arb_gnt_i(gnt),
    .bus_addr_o(addr), .bus_read_o(rd), .bus_write_o(wr),
    .bus_wdata_o(wdata), .bus_rdata_i(rdata), .bus_waitreq_i(waitreq)
  );

  assign rdata = rd ? rf[addr] : '0;

  task automatic chk(input bit ok, input string r, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  // behavioural reference: phase 0 idle,1 wait grant,2 lookup read,3 select read,4 write
  int m_ph = 0, m_idx = 0;
  logic [7:0] m_lut;
  logic [DW-1:0] m_wd;
  bit m_done = 0, m_err = 0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_ph = 0; m_done = 0; m_err = 0;
    end else begin
      m_done = 0; m_err = 0;
      case (m_ph)
        0: if (req) begin
             if (NCLK > 1 && int'(idx) < NCLK) begin m_ph = 1; m_idx = int'(idx); end
             else m_err = 1;
           end
        1: if (gnt) m_ph = 2;
        2: if (!waitreq) begin m_lut = rf[LU_A + m_idx][7:0]; m_ph = 3; end
        3: if (!waitreq) begin m_wd = {rf[SEL_A][DW-1:8], m_lut}; m_ph = 4; end
        4: if (!waitreq) begin m_ph = 0; m_done = 1; end
        default: m_ph = 0;
      endcase
      if (wr && !waitreq) rf[addr] <= wdata;
    end
  end

  // compare every cycle at the falling edge
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_wd;
  bit p_stall = 0, p_wr = 0, p_rd = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(busy == (m_ph != 0), "R1 busy", busy, m_ph != 0);
      chk(arb_req == (m_ph != 0), "R1 arb_req", arb_req, m_ph != 0);
      chk(rd == (m_ph == 2 || m_ph == 3), "R3 read", rd, m_ph);
      chk(wr == (m_ph == 4), "R3 write", wr, m_ph);
      chk(!(rd && wr) && (!(rd || wr) || arb_req), "R10 cmd", {rd, wr, arb_req}, 0);
      if (m_ph == 2) chk(addr == AW'(LU_A + m_idx), "R2 lookup addr", addr, LU_A + m_idx);
      if (m_ph == 3 || m_ph == 4) chk(addr == AW'(SEL_A), "R3 select addr", addr, SEL_A);
      if (m_ph == 4) chk(wdata == m_wd, "R4 write data", wdata, m_wd);
      chk(done == m_done, "R7 done", done, m_done);
      chk(err == m_err, "R6 err", err, m_err);
      if (p_stall) begin
        chk(rd == p_rd && wr == p_wr && addr == p_addr && (!wr || wdata == p_wd),
            "R5 hold", {rd, wr, addr}, {p_rd, p_wr, p_addr});
      end
      p_stall = (rd || wr) && waitreq;
      p_rd = rd; p_wr = wr; p_addr = addr; p_wd = wdata;
    end
  end

  // grant and stall patterns
  logic [7:0] lfsr = 8'h5b;
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    waitreq = lfsr[0] & lfsr[2];
    gnt = arb_req & lfsr[1];
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic fire(input int i);
    req = 1; idx = IW'(i);
    step(1);
    req = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200 && (busy || done); i++) step(1);
  endtask

  logic [DW-1:0] sel_init;
  initial begin
    for (int a = 0; a < (1 << AW); a++) rf[a] = 32'hC0DE_0000 | a;
    for (int n = 0; n < 5; n++) rf[LU_A + n] = 32'hF00D_A500 | 32'(8'h21 + 8'(n * 37));
    rf[SEL_A] = 32'h7E3C_91AA;
    sel_init  = rf[SEL_A];
    step(3);
    // R9 reset state
    chk(!busy && !done && !err && !arb_req && !rd && !wr, "R9 reset outputs",
        {busy, done, err, arb_req, rd, wr}, 0);
    rst_n = 1;
    step(2);
    for (int k = 0; k < 3; k++) begin
      for (int i = 0; i < NCLK; i++) begin
        fire(i);
        step(2);
        // R8: requests during a switch are ignored
        fire(NCLK);
        fire((i + 1) % NCLK);
        wait_idle();
        step(1);
        chk(rf[SEL_A] == {sel_init[DW-1:8], rf[LU_A + i][7:0]}, "R4 select reg",
            rf[SEL_A], {sel_init[DW-1:8], rf[LU_A + i][7:0]});
        chk(rf[LU_A + i][DW-1:8] == 24'hF00DA5, "R4 lookup untouched",
            rf[LU_A + i], 32'hF00D_A500);
      end
      // R6: out of range indices
      fire(NCLK);
      step(1);
      chk(!busy && !arb_req, "R6 no start", {busy, arb_req}, 0);
      fire(7);
      step(3);
      chk(!busy, "R6 no start top", busy, 0);
    end
    // back to back with request on done cycle
    fire(3);
    for (int i = 0; i < 200 && !done; i++) step(1);
    fire(1);
    wait_idle();
    step(1);
    chk(rf[SEL_A][7:0] == rf[LU_A + 1][7:0], "R7 request on done cycle",
        rf[SEL_A][7:0], rf[LU_A + 1][7:0]);
    step(4);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule